// File: doc/BRIEF.md
# SKP Ordered Set Filter and Error Checker

This block is the front end of a bit-error detector for a 128b/132b serial stream. It watches the incoming bits and finds the 132-bit block grid by looking for SYNC control blocks. Once it is locked to that grid, it frames every block and classifies it by its 4-bit header. Data blocks go to the output and to the bit comparator. Control blocks are dropped.

A control block that opens a SKP ordered set has a variable length. It carries an even number of SKP symbols, then one SKPEND symbol, then three state symbols. The next block header follows immediately after those. The block tracks this length, so clock-compensation material never reaches the comparator and the framing survives a set of any legal length.

SKP and SKPEND are recognised with a tolerance for bit errors. The comparator counts mismatching bits between each delivered payload and a reference payload supplied by the caller. The count is held in a saturating counter with a synchronous clear.

Top module: `skp_filter_checker`

## Requirements
- R1: While reset is held and after its release, `locked`, `payload_valid` and `err_count` are all zero until stimulus says otherwise.
- R2: A SYNC block is the control header followed by 16 symbols that alternate 8'h00, 8'hFF, starting with 8'h00. `locked` rises on the cycle after the last bit of a SYNC block whose last bit arrives exactly 132 accepted bits after the last bit of a previous SYNC block. A single SYNC, or two SYNCs at any other spacing, does not lock.
- R3: While unlocked, no payload is delivered and `err_count` does not change.
- R4: Bits arrive most significant first. A header is valid as 4'b1100 (data) or 4'b0011 (control). After a data header, the next 128 bits are delivered on `payload` with the first received bit in bit 127. `payload_valid` pulses for one cycle on the cycle after the last payload bit. `payload` holds its value between pulses.
- R5: A control block is dropped whole (128 bits, no payload) when its first symbol differs in 2 or more bits from both SKP (8'hCC) and SKPEND (8'h33).
- R6: A first control symbol within 1 bit of SKP starts a SKP set. A first control symbol within 1 bit of SKPEND is an empty set.
- R7: Inside a SKP set, a symbol within 3 bits of SKP is one more SKP. Any other symbol closes the set. Exactly three further symbols are then skipped, and the next bit is a block header.
- R8: Once 48 SKP symbols have been taken, the next symbol closes the set whatever its value.
- R9: A header that is neither valid code drops the next 128 bits uncompared. Four consecutive invalid headers clear `locked` on the cycle after the fourth header. A valid header restarts that count.
- R10: On each delivered payload, `err_count` grows by the number of bits in which `payload` differs from `ref_payload`. `ref_payload` is sampled in the cycle of the last payload bit, and the count updates together with `payload_valid`.
- R11: `err_count` saturates at all ones and never wraps.
- R12: `err_clr` zeroes `err_count` on the next edge and wins over a simultaneous update.
- R13: Cycles with `bit_vld` low advance nothing, whatever `bit_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_vld | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial stream bit |
| ref_payload | input | PAY_SYMS*8 | Expected payload for the data block now finishing |
| err_clr | input | 1 | Synchronous clear of the error count |
| locked | output | 1 | Block alignment achieved |
| payload_valid | output | 1 | One-cycle strobe for `payload` |
| payload | output | PAY_SYMS*8 | Payload of the last data block |
| err_count | output | CNT_W | Saturating bit-error count |

## Verification
The hardest situations to reach are those where tolerance decides the framing. Examples are a SKP carrying three flipped bits deep inside a set, a first symbol two bits away from SKP, and a run that reaches the 48-symbol cap with yet another SKP. The bench drives each of these from a table of SKP-set shapes that encodes the count, the flips per symbol position and the closing symbol. Every set is followed by a data block with a known number of corrupted reference bits. A misjudged symbol boundary therefore shows up as a shifted payload and a wrong error delta.

// File: rtl/skp_flt_pkg.sv
package skp_flt_pkg;
  localparam int HDR_W     = 4;
  localparam int SYM_W     = 8;
  localparam int TAIL_SYMS = 3;
  localparam int DIST_W    = $clog2(SYM_W + 1);

  localparam logic [HDR_W-1:0] HDR_DATA = 4'b1100;
  localparam logic [HDR_W-1:0] HDR_CTRL = 4'b0011;

  localparam logic [SYM_W-1:0] SYM_SKP    = 8'hCC;
  localparam logic [SYM_W-1:0] SYM_SKPEND = 8'h33;
  localparam logic [SYM_W-1:0] SYM_SYNC_A = 8'h00;
  localparam logic [SYM_W-1:0] SYM_SYNC_B = 8'hFF;

  // tolerance before and after the first SKP is known
  localparam logic [DIST_W-1:0] TOL_ENTRY = DIST_W'(1);
  localparam logic [DIST_W-1:0] TOL_INSET = DIST_W'(3);

  typedef enum logic [2:0] {
    FR_HDR, FR_DATA, FR_DROP, FR_CFIRST, FR_SKP, FR_TAIL
  } fr_state_e;

  function automatic logic [DIST_W-1:0] sym_dist(input logic [SYM_W-1:0] a,
                                                  input logic [SYM_W-1:0] b);
    return DIST_W'($countones(a ^ b));
  endfunction
endpackage

// File: rtl/skp_rst_sync.sv
module skp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage      <= 1'b1;
      rst_sync_n <= stage;
    end
  end
endmodule

// File: rtl/skp_sync_aligner.sv
module skp_sync_aligner
  import skp_flt_pkg::*;
#(
  parameter int PAY_SYMS   = 16,
  parameter int UNLOCK_BAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic hdr_good,
  input  logic hdr_bad,
  output logic locked
);
  localparam int PAY_W = PAY_SYMS * SYM_W;
  localparam int BLK_W = HDR_W + PAY_W;
  localparam int GW    = $clog2(BLK_W);
  localparam int BW    = $clog2(UNLOCK_BAD + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(BLK_W - 1);
  localparam logic [BW-1:0] BAD_LAST = BW'(UNLOCK_BAD - 1);

  logic [BLK_W-2:0] win;
  logic [BLK_W-1:0] win_n;
  logic [PAY_SYMS-1:0] sym_ok;
  logic sync_hit;
  logic seen, seen_n, locked_n;
  logic [GW-1:0] gap, gap_n;
  logic [BW-1:0] bad_cnt, bad_n;

  assign win_n = {win, bit_in};

  for (genvar g = 0; g < PAY_SYMS; g++) begin : g_sym
    assign sym_ok[g] = (win_n[PAY_W-1-g*SYM_W -: SYM_W] ==
                        (((g % 2) == 0) ? SYM_SYNC_A : SYM_SYNC_B));
  end

  assign sync_hit = (&sym_ok) && (win_n[BLK_W-1 -: HDR_W] == HDR_CTRL);

  always_comb begin
    locked_n = locked;
    seen_n   = seen;
    gap_n    = gap;
    bad_n    = bad_cnt;
    if (!locked) begin
      bad_n = '0;
      if (bit_vld) begin
        if (sync_hit) begin
          if (seen && (gap == GAP_LAST)) begin
            locked_n = 1'b1;
            seen_n   = 1'b0;
          end else begin
            seen_n = 1'b1;
            gap_n  = '0;
          end
        end else if (seen) begin
          if (gap == GAP_LAST) seen_n = 1'b0;
          else                 gap_n  = gap + GW'(1);
        end
      end
    end else begin
      seen_n = 1'b0;
      if (hdr_bad) begin
        if (bad_cnt == BAD_LAST) begin
          locked_n = 1'b0;
          bad_n    = '0;
        end else begin
          bad_n = bad_cnt + BW'(1);
        end
      end else if (hdr_good) begin
        bad_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win     <= '0;
      locked  <= 1'b0;
      seen    <= 1'b0;
      gap     <= '0;
      bad_cnt <= '0;
    end else begin
      if (bit_vld) win <= win_n[BLK_W-2:0];
      locked  <= locked_n;
      seen    <= seen_n;
      gap     <= gap_n;
      bad_cnt <= bad_n;
    end
  end
endmodule

// File: rtl/skp_block_framer.sv
module skp_block_framer
  import skp_flt_pkg::*;
#(
  parameter int PAY_SYMS = 16,
  parameter int MAX_SKP  = 48
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_vld,
  input  logic                          bit_in,
  input  logic                          locked,
  output logic                          hdr_good,
  output logic                          hdr_bad,
  output logic                          blk_done,
  output logic [PAY_SYMS*SYM_W-1:0]     blk_word,
  output logic                          out_valid,
  output logic [PAY_SYMS*SYM_W-1:0]     out_word
);
  localparam int PAY_W = PAY_SYMS * SYM_W;
  localparam int LW    = $clog2(PAY_W);
  localparam int NW    = $clog2(MAX_SKP + 1);
  localparam logic [LW-1:0] HDR_LAST  = LW'(HDR_W - 1);
  localparam logic [LW-1:0] SYM_LAST  = LW'(SYM_W - 1);
  localparam logic [LW-1:0] PAY_LAST  = LW'(PAY_W - 1);
  localparam logic [LW-1:0] REST_LAST = LW'(PAY_W - SYM_W - 1);
  localparam logic [LW-1:0] TAIL_LAST = LW'(TAIL_SYMS * SYM_W - 1);
  localparam logic [NW-1:0] SKP_CAP   = NW'(MAX_SKP);

  fr_state_e st, st_n;
  logic [LW-1:0] left, left_n;
  logic [SYM_W-2:0] fld;
  logic [SYM_W-1:0] fld_sh;
  logic [PAY_W-2:0] pay_sh;
  logic [PAY_W-1:0] pay_full;
  logic [PAY_W-2:0] pay_n;
  logic [NW-1:0] nskp, nskp_n;

  assign fld_sh   = {fld, bit_in};
  assign pay_full = {pay_sh, bit_in};
  assign blk_word = pay_full;

  always_comb begin
    st_n     = st;
    left_n   = left;
    pay_n    = pay_sh;
    nskp_n   = nskp;
    hdr_good = 1'b0;
    hdr_bad  = 1'b0;
    blk_done = 1'b0;
    if (!locked) begin
      st_n   = FR_HDR;
      left_n = HDR_LAST;
      nskp_n = '0;
    end else if (bit_vld) begin
      left_n = left - LW'(1);
      unique case (st)
        FR_HDR: if (left == '0) begin
          if (fld_sh[HDR_W-1:0] == HDR_DATA) begin
            st_n = FR_DATA;   left_n = PAY_LAST; hdr_good = 1'b1;
          end else if (fld_sh[HDR_W-1:0] == HDR_CTRL) begin
            st_n = FR_CFIRST; left_n = SYM_LAST; hdr_good = 1'b1;
          end else begin
            st_n = FR_DROP;   left_n = PAY_LAST; hdr_bad = 1'b1;
          end
        end
        FR_DATA: begin
          pay_n = pay_full[PAY_W-2:0];
          if (left == '0) begin
            blk_done = 1'b1;
            st_n     = FR_HDR;
            left_n   = HDR_LAST;
          end
        end
        FR_DROP: if (left == '0) begin
          st_n = FR_HDR; left_n = HDR_LAST;
        end
        FR_CFIRST: if (left == '0) begin
          if (sym_dist(fld_sh, SYM_SKP) <= TOL_ENTRY) begin
            st_n = FR_SKP;  left_n = SYM_LAST;  nskp_n = NW'(1);
          end else if (sym_dist(fld_sh, SYM_SKPEND) <= TOL_ENTRY) begin
            st_n = FR_TAIL; left_n = TAIL_LAST;
          end else begin
            st_n = FR_DROP; left_n = REST_LAST;
          end
        end
        FR_SKP: if (left == '0) begin
          if ((nskp == SKP_CAP) || (sym_dist(fld_sh, SYM_SKP) > TOL_INSET)) begin
            st_n = FR_TAIL; left_n = TAIL_LAST;
          end else begin
            nskp_n = nskp + NW'(1); left_n = SYM_LAST;
          end
        end
        FR_TAIL: if (left == '0) begin
          st_n = FR_HDR; left_n = HDR_LAST;
        end
        default: begin
          st_n = FR_HDR; left_n = HDR_LAST;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FR_HDR;
      left      <= HDR_LAST;
      fld       <= '0;
      pay_sh    <= '0;
      nskp      <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      st     <= st_n;
      left   <= left_n;
      pay_sh <= pay_n;
      nskp   <= nskp_n;
      if (bit_vld)  fld      <= fld_sh[SYM_W-2:0];
      out_valid <= blk_done;
      if (blk_done) out_word <= pay_full;
    end
  end
endmodule

// File: rtl/skp_err_counter.sv
module skp_err_counter #(
  parameter int PAY_W = 128,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_en,
  input  logic             clr,
  input  logic [PAY_W-1:0] word,
  input  logic [PAY_W-1:0] ref_word,
  output logic [CNT_W-1:0] count
);
  localparam int PW = $clog2(PAY_W + 1);
  localparam int SW = ((CNT_W > PW) ? CNT_W : PW) + 1;

  logic [PW-1:0] diff;
  logic [SW-1:0] sum;
  logic          ovf;
  logic [CNT_W-1:0] count_n;

  always_comb begin
    diff    = PW'($countones(word ^ ref_word));
    sum     = SW'(count) + SW'(diff);
    ovf     = |sum[SW-1:CNT_W];
    count_n = count;
    if (clr)         count_n = '0;
    else if (cmp_en) count_n = ovf ? '1 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end
endmodule

// File: rtl/skp_filter_checker.sv
module skp_filter_checker
  import skp_flt_pkg::*;
#(
  parameter int PAY_SYMS   = 16,
  parameter int MAX_SKP    = 48,
  parameter int UNLOCK_BAD = 4,
  parameter int CNT_W      = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_vld,
  input  logic                      bit_in,
  input  logic [PAY_SYMS*SYM_W-1:0] ref_payload,
  input  logic                      err_clr,
  output logic                      locked,
  output logic                      payload_valid,
  output logic [PAY_SYMS*SYM_W-1:0] payload,
  output logic [CNT_W-1:0]          err_count
);
  localparam int PAY_W = PAY_SYMS * SYM_W;

  logic rst_i_n;
  logic hdr_good, hdr_bad, blk_done;
  logic [PAY_W-1:0] blk_word;

  skp_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  skp_sync_aligner #(.PAY_SYMS(PAY_SYMS), .UNLOCK_BAD(UNLOCK_BAD)) u_align (
    .clk(clk), .rst_n(rst_i_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .hdr_good(hdr_good), .hdr_bad(hdr_bad), .locked(locked)
  );

  skp_block_framer #(.PAY_SYMS(PAY_SYMS), .MAX_SKP(MAX_SKP)) u_frame (
    .clk(clk), .rst_n(rst_i_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .locked(locked), .hdr_good(hdr_good), .hdr_bad(hdr_bad),
    .blk_done(blk_done), .blk_word(blk_word),
    .out_valid(payload_valid), .out_word(payload)
  );

  skp_err_counter #(.PAY_W(PAY_W), .CNT_W(CNT_W)) u_err (
    .clk(clk), .rst_n(rst_i_n), .cmp_en(blk_done), .clr(err_clr),
    .word(blk_word), .ref_word(ref_payload), .count(err_count)
  );
endmodule

// File: rtl/skp_filter_checker_sva.sv
module skp_filter_checker_sva #(
  parameter int PAY_W = 128,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld,
  input logic             err_clr,
  input logic             locked,
  input logic             payload_valid,
  input logic [PAY_W-1:0] payload,
  input logic [CNT_W-1:0] err_count
);
  AST_VALID_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    payload_valid |-> $past(locked)); // R3
  AST_LOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(bit_vld)); // R2
  AST_UNLOCK_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(bit_vld)); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    payload_valid |=> !payload_valid); // R4
  AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !payload_valid |-> $stable(payload)); // R4
  AST_COUNT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |-> (payload_valid || $past(err_clr))); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_clr) |-> (err_count == '0)); // R12
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(err_clr) |-> (err_count >= $past(err_count))); // R11
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_count) == '1) && !$past(err_clr)) |-> (err_count == '1)); // R11
endmodule

bind skp_filter_checker skp_filter_checker_sva #(
  .PAY_W(PAY_SYMS * 8), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .err_clr(err_clr),
  .locked(locked), .payload_valid(payload_valid), .payload(payload),
  .err_count(err_count)
);

// File: tb/skp_filter_checker_test.sv
module skp_filter_checker_test;
  localparam int CW = 8;

  // row: nskp[31:26] first_flip[25] skp_flip[24:23] end_flip[22:21]
  //      close_with_skp[20] ref_errors[19:16] seed[15:0]
  localparam logic [31:0] TAB [6] = '{
    {6'd0,  1'b1, 2'd0, 2'd0, 1'b0, 4'd0, 16'h1234},
    {6'd2,  1'b1, 2'd3, 2'd0, 1'b0, 4'd3, 16'hBEEF},
    {6'd36, 1'b0, 2'd2, 2'd3, 1'b0, 4'd0, 16'h0F0F},
    {6'd4,  1'b0, 2'd0, 2'd2, 1'b0, 4'd5, 16'h8001},
    {6'd48, 1'b0, 2'd0, 2'd0, 1'b1, 4'd1, 16'h7E57},
    {6'd10, 1'b1, 2'd3, 2'd3, 1'b0, 4'd0, 16'hC0DE}
  };

  logic clk, rst_n, bit_vld, bit_in, err_clr;
  logic [127:0] ref_payload, payload;
  logic locked, payload_valid;
  logic [CW-1:0] err_count;
  int n_chk, n_fail, pv_cnt;
  logic [127:0] last_pay;

  skp_filter_checker #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .ref_payload(ref_payload), .err_clr(err_clr), .locked(locked),
    .payload_valid(payload_valid), .payload(payload), .err_count(err_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    if (payload_valid) begin
      pv_cnt   = pv_cnt + 1;
      last_pay = payload;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_in = b; bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_field(input logic [127:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_data(input logic [127:0] p, input logic [127:0] r);
    ref_payload = r;
    send_field(128'b1100, 4);
    send_field(p, 128);
  endtask

  task automatic send_sync();
    send_field(128'b0011, 4);
    send_field({8{16'h00FF}}, 128);
  endtask

  task automatic send_bad();
    send_field(128'b0000, 4);
    send_field(128'h0, 128);
  endtask

  function automatic logic [7:0] flip(input logic [7:0] s, input int e);
    return s ^ ((8'd1 << e) - 8'd1);
  endfunction

  task automatic send_skp_set(input logic [31:0] row);
    int nskp;
    logic [7:0] s;
    nskp = int'(row[31:26]);
    send_field(128'b0011, 4);
    for (int i = 0; i <= nskp; i++) begin
      if (i < nskp) s = 8'hCC;
      else          s = row[20] ? 8'hCC : 8'h33;
      if (i == 0)           s = flip(s, int'(row[25]));
      else if (i < nskp)    s = flip(s, int'(row[24:23]));
      else                  s = flip(s, int'(row[22:21]));
      send_field({120'h0, s}, 8);
    end
    send_field({104'h0, 24'hCCCC33}, 24);
  endtask

  initial begin
    logic [127:0] p, m;
    int pv0;
    logic [CW-1:0] e0;
    n_chk = 0; n_fail = 0; pv_cnt = 0; last_pay = '0;
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; err_clr = 1'b0; ref_payload = '0;
    repeat (3) @(negedge clk);
    chk("R1 locked in reset", 128'(locked), 128'd0);
    chk("R1 payload_valid in reset", 128'(payload_valid), 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 err_count after reset", 128'(err_count), 128'd0);

    // R3: unlocked data is not delivered nor compared
    send_data({8{16'hA5A5}}, '0);
    send_data({8{16'h5A5A}}, '1);
    chk("R3 no payload unlocked", 128'(pv_cnt), 128'd0);
    chk("R3 no errors unlocked", 128'(err_count), 128'd0);

    // R2: misspaced SYNC pair does not lock, aligned pair does
    send_sync();
    send_bit(1'b0);
    send_sync();
    chk("R2 misspaced syncs", 128'(locked), 128'd0);
    send_sync();
    chk("R2 aligned syncs lock", 128'(locked), 128'd1);

    // R4: data block delivered
    p = {8{16'h1357}};
    send_data(p, p);
    chk("R4 payload", last_pay, p);
    chk("R4 one strobe", 128'(pv_cnt), 128'd1);

    // R5: SYNC while locked, and near-SKP first symbol, both dropped whole
    send_sync();
    send_field(128'b0011, 4);
    send_field({8'hCC ^ 8'h03, {15{8'hCC}}}, 128);
    chk("R5 control blocks dropped", 128'(pv_cnt), 128'd1);
    p = {8{16'h2468}};
    send_data(p, p);
    chk("R5 framing kept", last_pay, p);

    // R13: idle cycles with moving bit_in
    p = {8{16'hF00D}};
    ref_payload = p;
    send_field(128'b1100, 4);
    send_field(p >> 64, 64);
    for (int i = 0; i < 20; i++) begin bit_in = i[0]; @(negedge clk); end
    send_field(p, 64);
    chk("R13 enable gaps", last_pay, p);

    // table of SKP set shapes: R6 R7 R8 R10
    for (int r = 0; r < 6; r++) begin
      e0 = err_count;
      p  = {8{TAB[r][15:0]}};
      m  = (128'd1 << TAB[r][19:16]) - 128'd1;
      send_skp_set(TAB[r]);
      send_data(p, p ^ m);
      chk($sformatf("R6 R7 R8 skp row %0d payload", r), last_pay, p);
      chk($sformatf("R10 skp row %0d errors", r), 128'(err_count),
          128'(e0 + CW'(TAB[r][19:16])));
      for (int f = 0; f < 20; f++) send_data('0, '0);
    end

    // R12: clear, and clear beating an update
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk("R12 clear", 128'(err_count), 128'd0);
    p = {8{16'h0F1E}};
    pv0 = pv_cnt;
    ref_payload = ~p;
    send_field(128'b1100, 4);
    send_field(p >> 1, 127);
    err_clr = 1'b1;
    send_bit(p[0]);
    err_clr = 1'b0;
    chk("R12 clear wins", 128'(err_count), 128'd0);
    chk("R12 payload still out", 128'(pv_cnt), 128'(pv0 + 1));

    // R11: saturation
    send_data(p, ~p);
    chk("R10 full mismatch", 128'(err_count), 128'd128);
    send_data(p, ~p);
    chk("R11 saturate", 128'(err_count), 128'hFF);
    send_data(p, p ^ 128'h1F);
    chk("R11 stays saturated", 128'(err_count), 128'hFF);

    // R9: bad headers
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    pv0 = pv_cnt;
    for (int i = 0; i < 3; i++) send_bad();
    chk("R9 bad blocks dropped", 128'(pv_cnt), 128'(pv0));
    chk("R9 bad blocks uncompared", 128'(err_count), 128'd0);
    p = {8{16'hCAFE}};
    send_data(p, p);
    chk("R9 three bad keep lock", last_pay, p);
    for (int i = 0; i < 3; i++) send_bad();
    chk("R9 still locked after three", 128'(locked), 128'd1);
    send_field(128'b0101, 4);
    chk("R9 unlock on fourth", 128'(locked), 128'd0);
    send_field(128'h0, 128);
    pv0 = pv_cnt;
    send_data(p, ~p);
    chk("R3 no payload after unlock", 128'(pv_cnt), 128'(pv0));
    chk("R3 no errors after unlock", 128'(err_count), 128'd0);
    send_sync();
    send_sync();
    chk("R2 relock", 128'(locked), 128'd1);
    p = {8{16'h9BDF}};
    send_data(p, p);
    chk("R4 payload after relock", last_pay, p);

    summary();
  end
endmodule